// File: doc/BRIEF.md
# Adaptive Binary Probability Estimator

This block keeps one small adaptive estimate for each of a set of coding contexts. Each estimate pairs a 5-bit position in a fixed 30-entry table of less-probable-symbol probabilities with one bit that says which binary value is currently the more probable one. An arithmetic coder selects a context with `ctx_sel`. The block then presents, without delay, that context's 16-bit probability value and its more-probable-symbol sense.

The estimate changes only when the coder reports an interval renormalization. A renormalization after a more-probable symbol moves the context one table step toward a smaller probability. A renormalization after a less-probable symbol jumps a table-defined distance of 1, 2 or 3 steps toward a larger probability. At the top of the table, a less-probable jump that would pass the first entry stops at that entry and swaps the sense bit. Decisions that do not renormalize leave every context untouched.

Top module: `qe_estimator`

## Requirements
- R1: After synchronous reset every context reads table position 0 with more-probable sense 0, so `qe_out` is 16'h0AC1 and `mps_sense` is 0.
- R2: `qe_out` is the table value at the selected context's stored position. Positions 0 to 29 hold, in hex: 0AC1, 0A81, 0A01, 0901, 0701, 0681, 0601, 0501, 0481, 0441, 0381, 0301, 02C1, 0281, 0241, 0181, 0121, 00E1, 00A1, 0071, 0059, 0053, 0027, 0017, 0013, 000B, 0007, 0005, 0003, 0001.
- R3: A cycle with `renorm_valid`=1 and `renorm_is_lps`=0 at a position below 29 raises the selected context's position by one and keeps its sense. The result is visible on the outputs from the next cycle.
- R4: The same more-probable event at position 29 leaves the position at 29.
- R5: A cycle with `renorm_valid`=1 and `renorm_is_lps`=1 lowers the position by its jump distance and keeps the sense. The distance is 1 at positions 0 to 6, 3 at positions 24, 26 and 28, and 2 at every other position.
- R6: When a less-probable jump is larger than the current position, the position becomes 0 and the sense bit inverts.
- R7: A cycle with `renorm_valid`=0 changes no context.
- R8: An event changes only the context selected in that cycle. All other contexts keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_sel | input | CTX_W (4) | Context read and updated this cycle |
| renorm_valid | input | 1 | A renormalization happened this cycle |
| renorm_is_lps | input | 1 | 1: it followed a less-probable symbol; 0: a more-probable one |
| qe_out | output | 16 | Probability value of the selected context |
| mps_sense | output | 1 | More-probable binary value of the selected context |

## Verification
A long run of more-probable renormalizations on one context walks every table entry and then presses on the bottom limit, which separates a correct single step and floor from an off-by-one or wrap. Less-probable events at chosen positions tell the three jump distances apart, and repeated events at position 0 show the sense flipping back and forth. A pseudo-random mix of contexts, event kinds and idle cycles, followed by a sweep of untouched contexts, exposes writes to the wrong slot and updates on idle cycles.

// File: rtl/qe_est_pkg.sv
package qe_est_pkg;

    localparam int QE_W     = 16;
    localparam int IDX_W    = 5;
    localparam int NUM_QE   = 30;
    localparam int LAST_IDX = NUM_QE - 1;
    localparam int JUMP_W   = 2;

    typedef logic [IDX_W-1:0]  qe_idx_t;
    typedef logic [QE_W-1:0]   qe_val_t;
    typedef logic [JUMP_W-1:0] qe_jump_t;

    typedef enum logic {
        EV_MPS = 1'b0,
        EV_LPS = 1'b1
    } renorm_kind_e;

    typedef struct packed {
        logic    mps;
        qe_idx_t idx;
    } est_state_t;

    function automatic qe_val_t qe_of(qe_idx_t i);
        case (i)
            5'd0:  return 16'h0AC1;
            5'd1:  return 16'h0A81;
            5'd2:  return 16'h0A01;
            5'd3:  return 16'h0901;
            5'd4:  return 16'h0701;
            5'd5:  return 16'h0681;
            5'd6:  return 16'h0601;
            5'd7:  return 16'h0501;
            5'd8:  return 16'h0481;
            5'd9:  return 16'h0441;
            5'd10: return 16'h0381;
            5'd11: return 16'h0301;
            5'd12: return 16'h02C1;
            5'd13: return 16'h0281;
            5'd14: return 16'h0241;
            5'd15: return 16'h0181;
            5'd16: return 16'h0121;
            5'd17: return 16'h00E1;
            5'd18: return 16'h00A1;
            5'd19: return 16'h0071;
            5'd20: return 16'h0059;
            5'd21: return 16'h0053;
            5'd22: return 16'h0027;
            5'd23: return 16'h0017;
            5'd24: return 16'h0013;
            5'd25: return 16'h000B;
            5'd26: return 16'h0007;
            5'd27: return 16'h0005;
            5'd28: return 16'h0003;
            5'd29: return 16'h0001;
            default: return 16'h0001;
        endcase
    endfunction

    function automatic qe_jump_t jump_of(qe_idx_t i);
        if (i <= qe_idx_t'(6))
            return qe_jump_t'(1);
        else if (i == qe_idx_t'(24) || i == qe_idx_t'(26) || i == qe_idx_t'(28))
            return qe_jump_t'(3);
        else
            return qe_jump_t'(2);
    endfunction

endpackage

// File: rtl/qe_table_lookup.sv
module qe_table_lookup
    import qe_est_pkg::*;
(
    input  qe_idx_t  idx,
    output qe_val_t  qe,
    output qe_jump_t jump
);
    assign qe   = qe_of(idx);
    assign jump = jump_of(idx);
endmodule

// File: rtl/qe_state_step.sv
module qe_state_step
    import qe_est_pkg::*;
(
    input  est_state_t   cur,
    input  renorm_kind_e kind,
    input  qe_jump_t     jump,
    output est_state_t   nxt
);
    always_comb begin
        nxt = cur;
        if (kind == EV_LPS) begin
            if (cur.idx < qe_idx_t'(jump)) begin
                nxt.idx = '0;
                nxt.mps = ~cur.mps;
            end else begin
                nxt.idx = cur.idx - qe_idx_t'(jump);
            end
        end else if (cur.idx != qe_idx_t'(LAST_IDX)) begin
            nxt.idx = cur.idx + qe_idx_t'(1);
        end
    end
endmodule

// File: rtl/qe_ctx_store.sv
module qe_ctx_store
    import qe_est_pkg::*;
#(
    parameter  int NUM_CTX = 16,
    localparam int CTX_W   = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTX_W-1:0] rd_ctx,
    output est_state_t       rd_state,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_ctx,
    input  est_state_t       wr_state
);
    est_state_t slots [NUM_CTX];

    for (genvar gi = 0; gi < NUM_CTX; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[gi] <= '0;
            else if (wr_en && wr_ctx == CTX_W'(gi))
                slots[gi] <= wr_state;
        end

        // R7, R8: a slot not addressed by a write keeps its contents
        a_r8_other_ctx_kept: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_ctx == CTX_W'(gi)) |=> $stable(slots[gi]));
    end

    assign rd_state = slots[rd_ctx];
endmodule

// File: rtl/qe_estimator.sv
module qe_estimator
    import qe_est_pkg::*;
#(
    parameter  int NUM_CTX = 16,
    localparam int CTX_W   = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTX_W-1:0] ctx_sel,
    input  logic             renorm_valid,
    input  logic             renorm_is_lps,
    output logic [QE_W-1:0]  qe_out,
    output logic             mps_sense
);
    est_state_t   cur_state;
    est_state_t   nxt_state;
    qe_jump_t     cur_jump;
    renorm_kind_e kind;

    assign kind = renorm_is_lps ? EV_LPS : EV_MPS;

    qe_ctx_store #(.NUM_CTX(NUM_CTX)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_ctx   (ctx_sel),
        .rd_state (cur_state),
        .wr_en    (renorm_valid),
        .wr_ctx   (ctx_sel),
        .wr_state (nxt_state)
    );

    qe_table_lookup u_lookup (
        .idx  (cur_state.idx),
        .qe   (qe_out),
        .jump (cur_jump)
    );

    qe_state_step u_step (
        .cur  (cur_state),
        .kind (kind),
        .jump (cur_jump),
        .nxt  (nxt_state)
    );

    assign mps_sense = cur_state.mps;

    // R2: output always lies inside the table's range
    a_r2_qe_in_range: assert property (@(posedge clk) disable iff (rst)
        (qe_out != '0) && (qe_out <= 16'h0AC1));

    a_r3_mps_step: assert property (@(posedge clk) disable iff (rst)
        (renorm_valid && !renorm_is_lps && cur_state.idx < qe_idx_t'(LAST_IDX))
        |=> ($stable(ctx_sel) -> (cur_state.idx == $past(cur_state.idx) + qe_idx_t'(1)
                                  && cur_state.mps == $past(cur_state.mps))));

    a_r4_mps_floor: assert property (@(posedge clk) disable iff (rst)
        (renorm_valid && !renorm_is_lps && cur_state.idx == qe_idx_t'(LAST_IDX))
        |=> ($stable(ctx_sel) -> (cur_state.idx == qe_idx_t'(LAST_IDX))));

    a_r5_lps_rises: assert property (@(posedge clk) disable iff (rst)
        (renorm_valid && renorm_is_lps && cur_state.idx > qe_idx_t'(0))
        |=> ($stable(ctx_sel) -> (cur_state.idx < $past(cur_state.idx)
                                  && cur_state.mps == $past(cur_state.mps))));

    a_r6_sense_swap: assert property (@(posedge clk) disable iff (rst)
        (renorm_valid && renorm_is_lps && cur_state.idx == qe_idx_t'(0))
        |=> ($stable(ctx_sel) -> (cur_state.idx == qe_idx_t'(0)
                                  && cur_state.mps != $past(cur_state.mps))));
endmodule

// File: tb/test_qe_estimator.sv
module test_qe_estimator;
    localparam int NCTX = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  ctx_sel;
    logic        renorm_valid;
    logic        renorm_is_lps;
    logic [15:0] qe_out;
    logic        mps_sense;

    always #10 clk = ~clk;

    qe_estimator #(.NUM_CTX(NCTX)) i_qe_estimator (
        .clk           (clk),
        .rst           (rst),
        .ctx_sel       (ctx_sel),
        .renorm_valid  (renorm_valid),
        .renorm_is_lps (renorm_is_lps),
        .qe_out        (qe_out),
        .mps_sense     (mps_sense)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    m_idx [NCTX];
    bit    m_mps [NCTX];
    string last_tag = "R1";
    logic [15:0] qe_tab [30] = '{
        16'h0AC1, 16'h0A81, 16'h0A01, 16'h0901, 16'h0701, 16'h0681,
        16'h0601, 16'h0501, 16'h0481, 16'h0441, 16'h0381, 16'h0301,
        16'h02C1, 16'h0281, 16'h0241, 16'h0181, 16'h0121, 16'h00E1,
        16'h00A1, 16'h0071, 16'h0059, 16'h0053, 16'h0027, 16'h0017,
        16'h0013, 16'h000B, 16'h0007, 16'h0005, 16'h0003, 16'h0001 };

    // R5 jump distances
    function automatic int jump_dist(int i);
        if (i <= 6) return 1;
        if (i == 24 || i == 26 || i == 28) return 3;
        return 2;
    endfunction

    // One cycle: drive inputs, compare outputs with model, then advance model.
    task automatic drive_cycle(int ctx, bit v, bit lps, string tag);
        string t;
        @(negedge clk);
        ctx_sel = ctx[3:0];
        renorm_valid = v;
        renorm_is_lps = lps;
        #1;
        t = (tag != "") ? tag : last_tag;
        n_cmp++;
        if (qe_out !== qe_tab[m_idx[ctx]] || mps_sense !== m_mps[ctx]) begin
            n_bad++;
            $display("FAIL %s R2 ctx=%0d actual qe=%h mps=%b expected qe=%h mps=%b",
                     t, ctx, qe_out, mps_sense, qe_tab[m_idx[ctx]], m_mps[ctx]);
        end
        if (!v) begin
            last_tag = "R7";
        end else if (!lps) begin
            if (m_idx[ctx] == 29) last_tag = "R4";
            else begin last_tag = "R3"; m_idx[ctx]++; end
        end else begin
            if (m_idx[ctx] < jump_dist(m_idx[ctx])) begin
                last_tag = "R6";
                m_idx[ctx] = 0;
                m_mps[ctx] = ~m_mps[ctx];
            end else begin
                last_tag = "R5";
                m_idx[ctx] -= jump_dist(m_idx[ctx]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lfsr;
        for (int i = 0; i < NCTX; i++) begin m_idx[i] = 0; m_mps[i] = 1'b0; end
        rst = 1'b1;
        ctx_sel = '0;
        renorm_valid = 1'b0;
        renorm_is_lps = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every context starts at the first table entry
        for (int c = 0; c < NCTX; c++) drive_cycle(c, 1'b0, 1'b0, "R1");

        // R3 and R4: walk one context through the whole table and past its end
        for (int k = 0; k < 35; k++) drive_cycle(3, 1'b1, 1'b0, "");
        drive_cycle(3, 1'b0, 1'b0, "");

        // R5: jumps from 29, 28, 26, 24 and from the upper region
        drive_cycle(3, 1'b1, 1'b1, "");           // 29 -> 27
        drive_cycle(3, 1'b1, 1'b0, "");           // 27 -> 28
        drive_cycle(3, 1'b1, 1'b1, "");           // 28 -> 25
        drive_cycle(3, 1'b1, 1'b0, "");           // 25 -> 26
        drive_cycle(3, 1'b1, 1'b1, "");           // 26 -> 23
        drive_cycle(3, 1'b1, 1'b0, "");           // 23 -> 24
        drive_cycle(3, 1'b1, 1'b1, "");           // 24 -> 21
        for (int k = 0; k < 12; k++) drive_cycle(3, 1'b1, 1'b1, "");
        drive_cycle(3, 1'b0, 1'b0, "");

        // R6: repeated less-probable events at position 0 toggle the sense
        drive_cycle(5, 1'b1, 1'b1, "");
        drive_cycle(5, 1'b1, 1'b1, "");
        drive_cycle(5, 1'b1, 1'b1, "");
        drive_cycle(5, 1'b0, 1'b0, "");

        // R8: hammer one context, then confirm the others are unchanged
        for (int k = 0; k < 10; k++) drive_cycle(7, 1'b1, k[1], "");
        for (int c = 0; c < NCTX; c++) drive_cycle(c, 1'b0, 1'b0, "R8");

        // R7 and R8: pseudo-random mix of contexts, kinds and idle cycles
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 4000; k++) begin
            lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
            drive_cycle(lfsr[7:4], lfsr[9:8] != 2'b00, lfsr[12:11] == 2'b00, "");
        end
        for (int c = 0; c < NCTX; c++) drive_cycle(c, 1'b0, 1'b0, "R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule